// File: doc/BRIEF.md
# Tiled Display Pixel Generator

This block sits in the scanline path of a tiled video display. It receives one cell at a time: a 16-bit tile entry and the glyph row bits already fetched from tile memory. It emits one 8-bit colour index per native pixel, with a valid strobe, over consecutive cycles. Three pixel formats are supported. A text-style mode uses one bit per pixel with per-cell foreground and background colours. Two indexed modes use four or eight bits per pixel, and their entries carry mirror flags and a palette bank.

A second, purely combinational port turns a tile entry into the glyph-row address that the memory side should read for the current scanline. It applies the vertical mirror and the tracked row within the cell. An internal row counter follows the frame. A frame pulse loads the vertical fine-scroll offset, and each end-of-line pulse advances the counter. The counter wraps at the last displayed row, so a displayed height shorter than the cell height (for example 11 of 16 lines) sets the vertical tile pitch. Horizontal fine scroll drops leading pixels from the first cell of each line.

Top module: `tpg_tile_pixel_gen`

## Requirements
- R1: While reset is held and in the cycle after it is released, `pix_valid` is 0 and `cell_ready` is 1.
- R2: With `mode`=0 (text), entry bits [7:0] are the glyph, [11:8] the foreground and [15:12] the background. Pixel p (p=0 leftmost) is bit (7-p) of `cell_glyph`. A set bit gives index {4'h0, foreground} and a clear bit gives {4'h0, background}.
- R3: With `mode`=1 (4-bit), pixel p is `cell_glyph[31-4p -: 4]` and the index is {entry[15:12], pixel}.
- R4: With `mode`=2 or 3 (8-bit), pixel p is the byte `cell_glyph[63-8p -: 8]` and the index is that byte with entry[15:12] XORed into its upper nibble.
- R5: In modes 1 to 3, entry bit 10 set reverses the pixel order of the cell. In mode 0 that bit is part of the foreground colour and reverses nothing.
- R6: An accepted cell (`cell_valid` and `cell_ready` both high at a clock edge) shows its first pixel in the next cycle, with the rest on consecutive cycles. `cell_ready` is low during every pixel but the last one. A cell offered during the last pixel is accepted and follows with no gap.
- R7: The first cell accepted after reset or after a `line_start` pulse begins at pixel position `fine_h` and emits 8-`fine_h` pixels. Later cells in the line emit all 8.
- R8: A `line_start` in the same cycle as an acceptance makes that cell the first of the line. A `line_start` while a cell is mid-way, with no acceptance, discards that cell's remaining pixels, and `pix_valid` is 0 in the next cycle.
- R9: `lk_addr` is glyph×16+row when `cell_tall`=1 and glyph×8+row when `cell_tall`=0. In mode 0 the glyph is entry bits [7:0]. In the other modes it is entry bits [9:0].
- R10: The last displayed row is `row_last`, capped at 7 when `cell_tall`=0. `frame_start` loads the row with `fine_v`, or with 0 if `fine_v` exceeds the last displayed row. `line_end` advances the row by one and wraps to 0 after the last displayed row.
- R11: In modes 1 to 3, entry bit 11 set makes the lookup use row (last displayed row - row). In mode 0 bit 11 is background colour and has no mirror effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Pixel format: 0 text, 1 4-bit, 2/3 8-bit |
| cell_tall | input | 1 | 1 selects 16-line cells, 0 selects 8-line cells |
| row_last | input | 4 | Last displayed row within a cell |
| fine_h | input | 3 | Horizontal fine scroll in pixels |
| fine_v | input | 4 | Vertical fine scroll in lines, loaded per frame |
| frame_start | input | 1 | Pulse: load the row counter from `fine_v` |
| line_start | input | 1 | Pulse: a new line begins (arms fine_h, drops pending pixels) |
| line_end | input | 1 | Pulse: advance the row counter |
| lk_entry | input | 16 | Tile entry to translate into a fetch address |
| lk_addr | output | 14 | Glyph-row address for `lk_entry` at the current row |
| cell_valid | input | 1 | A cell is offered |
| cell_ready | output | 1 | The offered cell is taken at this edge |
| cell_entry | input | 16 | Tile entry of the offered cell |
| cell_glyph | input | 64 | Glyph row bits of the offered cell |
| pix_valid | output | 1 | `pix_index` carries a pixel this cycle |
| pix_index | output | 8 | Colour index of the current pixel |

## Verification
The line re-arm pulse and a cell hand-over can land in the same cycle. The bench provokes this by raising `line_start` together with `cell_valid` while the generator is idle, for every odd `fine_h`. It judges the result by the pixel count and the first pixel position of that cell. It also raises `line_start` with no cell offered while a cell is half drawn, and expects `pix_valid` low in the next cycle. The following cell must then still honour `fine_h`. Back-to-back cells are offered during the last pixel of the previous cell, and `pix_valid` must stay high with no gap.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

   localparam logic [1:0] MODE_TEXT = 2'd0;
   localparam logic [1:0] MODE_IDX4 = 2'd1;

   typedef struct packed {
      logic [9:0] glyph;
      logic       hflip;
      logic       vflip;
      logic [3:0] bank;
      logic [3:0] fg;
      logic [3:0] bg;
   } tpg_attr_t;

   // One entry word, two readings depending on the pixel format
   function automatic tpg_attr_t tpg_decode(input logic [1:0] mode, input logic [15:0] e);
      tpg_attr_t a;
      a.fg   = e[11:8];
      a.bg   = e[15:12];
      a.bank = e[15:12];
      if (mode == MODE_TEXT) begin
         a.glyph = {2'b00, e[7:0]};
         a.hflip = 1'b0;
         a.vflip = 1'b0;
      end else begin
         a.glyph = e[9:0];
         a.hflip = e[10];
         a.vflip = e[11];
      end
      return a;
   endfunction

endpackage

// File: rtl/tpg_row_track.sv
module tpg_row_track #(
   parameter int ROW_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             line_end,
   input  logic [ROW_W-1:0] fine_v,
   input  logic [ROW_W-1:0] last_row,
   output logic [ROW_W-1:0] row
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row <= '0;
      end else if (frame_start) begin
         row <= (fine_v > last_row) ? '0 : fine_v;
      end else if (line_end) begin
         row <= (row >= last_row) ? '0 : row + 1'b1;
      end
   end

endmodule

// File: rtl/tpg_fetch_addr.sv
module tpg_fetch_addr
   import tpg_pkg::*;
#(
   parameter int GLYPH_W = 10,
   parameter int ROW_W   = 4,
   localparam int ADDR_W = GLYPH_W + ROW_W
) (
   input  logic [1:0]        mode,
   input  logic              tall,
   input  logic [ROW_W-1:0]  row,
   input  logic [ROW_W-1:0]  last_row,
   input  logic [15:0]       entry,
   output logic [ADDR_W-1:0] addr
);

   tpg_attr_t        attr;
   logic [ROW_W-1:0] row_eff;
   logic             unused_fields;

   always_comb begin
      attr    = tpg_decode(mode, entry);
      row_eff = attr.vflip ? (last_row - row) : row;
      if (tall) begin
         addr = {attr.glyph, row_eff};
      end else begin
         addr = {1'b0, attr.glyph, row_eff[ROW_W-2:0]};
      end
   end

   assign unused_fields = ^{attr.fg, attr.bg, attr.bank, attr.hflip, row_eff[ROW_W-1]};

endmodule

// File: rtl/tpg_pix_lanes.sv
module tpg_pix_lanes
   import tpg_pkg::*;
#(
   parameter int CELL_W   = 8,
   parameter int IDX_W    = 8,
   parameter int HFLIP_EN = 1,
   localparam int NIB_W   = IDX_W / 2,
   localparam int ROW_BITS = CELL_W * IDX_W
) (
   input  logic [1:0]          mode,
   input  logic [15:0]         entry,
   input  logic [ROW_BITS-1:0] row_bits,
   output logic [ROW_BITS-1:0] lanes
);

   tpg_attr_t           attr;
   logic [ROW_BITS-1:0] raw;
   logic                unused_fields;

   assign attr = tpg_decode(mode, entry);

   for (genvar p = 0; p < CELL_W; p++) begin : g_lane
      logic             bit1;
      logic [NIB_W-1:0] nib;
      logic [IDX_W-1:0] byt;
      assign bit1 = row_bits[CELL_W-1-p];
      assign nib  = row_bits[(CELL_W-p)*NIB_W-1 -: NIB_W];
      assign byt  = row_bits[(CELL_W-p)*IDX_W-1 -: IDX_W];
      assign raw[p*IDX_W +: IDX_W] =
         (mode == MODE_TEXT) ? {{NIB_W{1'b0}}, (bit1 ? attr.fg : attr.bg)} :
         (mode == MODE_IDX4) ? {attr.bank, nib} :
                               {byt[IDX_W-1:NIB_W] ^ attr.bank, byt[NIB_W-1:0]};
   end

   if (HFLIP_EN != 0) begin : g_flip
      for (genvar p = 0; p < CELL_W; p++) begin : g_sel
         assign lanes[p*IDX_W +: IDX_W] = attr.hflip ? raw[(CELL_W-1-p)*IDX_W +: IDX_W]
                                                     : raw[p*IDX_W +: IDX_W];
      end
      assign unused_fields = ^{attr.glyph, attr.vflip};
   end else begin : g_noflip
      assign lanes = raw;
      assign unused_fields = ^{attr.glyph, attr.vflip, attr.hflip};
   end

endmodule

// File: rtl/tpg_serializer.sv
module tpg_serializer #(
   parameter int CELL_W = 8,
   parameter int IDX_W  = 8,
   localparam int COL_W = $clog2(CELL_W),
   localparam int ROW_BITS = CELL_W * IDX_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                drop,
   input  logic [COL_W-1:0]    start_pos,
   input  logic [ROW_BITS-1:0] lanes_in,
   output logic                busy,
   output logic                at_last,
   output logic [IDX_W-1:0]    pix_index
);

   localparam logic [COL_W-1:0] LAST_POS = COL_W'(CELL_W - 1);

   logic [ROW_BITS-1:0] lanes_q;
   logic [COL_W-1:0]    pos;

   assign at_last   = (pos == LAST_POS);
   assign pix_index = lanes_q[pos*IDX_W +: IDX_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         pos     <= '0;
         lanes_q <= '0;
      end else if (load) begin
         busy    <= 1'b1;
         pos     <= start_pos;
         lanes_q <= lanes_in;
      end else if (drop) begin
         busy <= 1'b0;
      end else if (busy) begin
         if (at_last) begin
            busy <= 1'b0;
         end else begin
            pos <= pos + 1'b1;
         end
      end
   end

endmodule

// File: rtl/tpg_tile_pixel_gen.sv
module tpg_tile_pixel_gen #(
   parameter int CELL_W   = 8,
   parameter int ROW_MAX  = 16,
   parameter int GLYPH_W  = 10,
   parameter int IDX_W    = 8,
   parameter int ENTRY_W  = 16,
   parameter int HFLIP_EN = 1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [1:0]                            mode,
   input  logic                                  cell_tall,
   input  logic [$clog2(ROW_MAX)-1:0]            row_last,
   input  logic [$clog2(CELL_W)-1:0]             fine_h,
   input  logic [$clog2(ROW_MAX)-1:0]            fine_v,
   input  logic                                  frame_start,
   input  logic                                  line_start,
   input  logic                                  line_end,
   input  logic [ENTRY_W-1:0]                    lk_entry,
   output logic [GLYPH_W+$clog2(ROW_MAX)-1:0]    lk_addr,
   input  logic                                  cell_valid,
   output logic                                  cell_ready,
   input  logic [ENTRY_W-1:0]                    cell_entry,
   input  logic [CELL_W*IDX_W-1:0]               cell_glyph,
   output logic                                  pix_valid,
   output logic [IDX_W-1:0]                      pix_index
);

   localparam int COL_W    = $clog2(CELL_W);
   localparam int ROW_W    = $clog2(ROW_MAX);
   localparam int ADDR_W   = GLYPH_W + ROW_W;
   localparam int ROW_BITS = CELL_W * IDX_W;
   localparam logic [ROW_W-1:0] SHORT_LAST = ROW_W'(ROW_MAX / 2 - 1);

   // Elaboration-time parameter checks
   if (ENTRY_W != 16 || GLYPH_W != 10 || IDX_W != 8) begin : g_bad_fields
      $error("tile entry layout needs ENTRY_W=16, GLYPH_W=10, IDX_W=8");
   end
   if (CELL_W < 2 || (CELL_W & (CELL_W - 1)) != 0 || CELL_W * 4 > ROW_BITS) begin : g_bad_cell
      $error("CELL_W must be a power of two of at least 2");
   end
   if (ROW_MAX < 4 || (ROW_MAX & (ROW_MAX - 1)) != 0) begin : g_bad_rows
      $error("ROW_MAX must be a power of two of at least 4");
   end

   logic [ROW_W-1:0]    row_cur;
   logic [ROW_W-1:0]    row_last_eff;
   logic [ROW_BITS-1:0] lanes;
   logic                busy;
   logic                at_last;
   logic                load;
   logic                first_q;
   logic [COL_W-1:0]    start_pos;

   // R10: short cells cap the displayed height
   assign row_last_eff = (!cell_tall && row_last > SHORT_LAST) ? SHORT_LAST : row_last;

   tpg_row_track #(.ROW_W(ROW_W)) u_rows (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .line_end    (line_end),
      .fine_v      (fine_v),
      .last_row    (row_last_eff),
      .row         (row_cur)
   );

   tpg_fetch_addr #(.GLYPH_W(GLYPH_W), .ROW_W(ROW_W)) u_fetch (
      .mode     (mode),
      .tall     (cell_tall),
      .row      (row_cur),
      .last_row (row_last_eff),
      .entry    (lk_entry),
      .addr     (lk_addr)
   );

   tpg_pix_lanes #(.CELL_W(CELL_W), .IDX_W(IDX_W), .HFLIP_EN(HFLIP_EN)) u_lanes (
      .mode     (mode),
      .entry    (cell_entry),
      .row_bits (cell_glyph),
      .lanes    (lanes)
   );

   // R6: hand-over is allowed when idle or on the final pixel
   assign cell_ready = !busy || at_last;
   assign load       = cell_valid && cell_ready;
   // R7/R8: the first cell of a line skips fine_h pixels
   assign start_pos  = (first_q || line_start) ? fine_h : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q <= 1'b1;
      end else if (load) begin
         first_q <= 1'b0;
      end else if (line_start) begin
         first_q <= 1'b1;
      end
   end

   tpg_serializer #(.CELL_W(CELL_W), .IDX_W(IDX_W)) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .drop      (line_start),
      .start_pos (start_pos),
      .lanes_in  (lanes),
      .busy      (busy),
      .at_last   (at_last),
      .pix_index (pix_index)
   );

   assign pix_valid = busy;

endmodule

// File: rtl/tpg_tile_pixel_gen_chk.sv
module tpg_tile_pixel_gen_chk #(
   parameter int ROW_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_start,
   input logic             line_start,
   input logic             line_end,
   input logic             cell_valid,
   input logic             cell_ready,
   input logic             pix_valid,
   input logic [ROW_W-1:0] fine_v,
   input logic [ROW_W-1:0] row_cur,
   input logic [ROW_W-1:0] row_last_eff
);

   // R6
   accept_shows_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_valid && cell_ready) |=> pix_valid);

   // R6
   stall_only_when_drawing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_ready |-> pix_valid);

   // R8
   line_start_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !(cell_valid && cell_ready)) |=> !pix_valid);

   // R10
   row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_end && !frame_start && row_cur >= row_last_eff) |=> (row_cur == '0));

   // R10
   row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_end && !frame_start && row_cur < row_last_eff) |=> (row_cur == $past(row_cur) + 1'b1));

   // R10
   frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && fine_v <= row_last_eff) |=> (row_cur == $past(fine_v)));

endmodule

bind tpg_tile_pixel_gen tpg_tile_pixel_gen_chk #(.ROW_W(ROW_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_start  (frame_start),
   .line_start   (line_start),
   .line_end     (line_end),
   .cell_valid   (cell_valid),
   .cell_ready   (cell_ready),
   .pix_valid    (pix_valid),
   .fine_v       (fine_v),
   .row_cur      (row_cur),
   .row_last_eff (row_last_eff)
);

// File: tb/tpg_tile_pixel_gen_bench.sv
module tpg_tile_pixel_gen_bench;

   localparam int CLK_PERIOD = 10;
   localparam int CW = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  mode;
   logic        cell_tall;
   logic [3:0]  row_last;
   logic [2:0]  fine_h;
   logic [3:0]  fine_v;
   logic        frame_start, line_start, line_end;
   logic [15:0] lk_entry;
   logic [13:0] lk_addr;
   logic        cell_valid, cell_ready;
   logic [15:0] cell_entry;
   logic [63:0] cell_glyph;
   logic        pix_valid;
   logic [7:0]  pix_index;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tpg_tile_pixel_gen u_tpg_tile_pixel_gen (
      .clk(clk), .rst_n(rst_n), .mode(mode), .cell_tall(cell_tall),
      .row_last(row_last), .fine_h(fine_h), .fine_v(fine_v),
      .frame_start(frame_start), .line_start(line_start), .line_end(line_end),
      .lk_entry(lk_entry), .lk_addr(lk_addr),
      .cell_valid(cell_valid), .cell_ready(cell_ready),
      .cell_entry(cell_entry), .cell_glyph(cell_glyph),
      .pix_valid(pix_valid), .pix_index(pix_index)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Expected colour index of output position pos, derived from R2..R5
   function automatic logic [7:0] exp_pix(input int m, input logic [15:0] e, input logic [63:0] g, input int pos);
      int src;
      logic [3:0] nib;
      logic [7:0] byt;
      src = pos;
      if (m != 0 && e[10]) src = CW - 1 - pos;
      if (m == 0) begin
         return ((g >> (CW - 1 - src)) & 64'h1) != 0 ? {4'h0, e[11:8]} : {4'h0, e[15:12]};
      end
      nib = 4'((g >> (4 * (CW - 1 - src))) & 64'hF);
      if (m == 1) return {e[15:12], nib};
      byt = 8'((g >> (8 * (CW - 1 - src))) & 64'hFF);
      return {byt[7:4] ^ e[15:12], byt[3:0]};
   endfunction

   task automatic run_cell(input int m, input logic [15:0] e, input logic [63:0] g,
                           input int start, input bit with_line, input string req);
      @(negedge clk);
      cell_entry = e; cell_glyph = g; cell_valid = 1'b1; line_start = with_line;
      @(negedge clk);
      cell_valid = 1'b0; line_start = 1'b0;
      for (int p = start; p < CW; p++) begin
         chk(req, "pix_valid", 32'(pix_valid), 32'd1);
         chk(req, "pix_index", 32'(pix_index), 32'(exp_pix(m, e, g, p)));
         chk("R6", "cell_ready", 32'(cell_ready), 32'(p == CW - 1));
         if (p < CW - 1) @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R6 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] base;
      logic [15:0] e;
      logic [63:0] g;
      logic [63:0] g2;
      string req;

      rst_n = 1'b0; mode = 2'd0; cell_tall = 1'b0; row_last = 4'd7;
      fine_h = 3'd0; fine_v = 4'd0; frame_start = 1'b0; line_start = 1'b0;
      line_end = 1'b0; lk_entry = 16'h0; cell_valid = 1'b0;
      cell_entry = 16'h0; cell_glyph = 64'h0;
      base = 64'h0123_4567_89AB_CDEF;

      repeat (3) @(negedge clk);
      chk("R1", "pix_valid in reset", 32'(pix_valid), 32'd0);
      chk("R1", "cell_ready in reset", 32'(cell_ready), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "pix_valid after reset", 32'(pix_valid), 32'd0);
      chk("R1", "cell_ready after reset", 32'(cell_ready), 32'd1);

      // Format sweep: R2 text, R3 4-bit, R4 8-bit, R5 mirror
      for (int m = 0; m < 4; m++) begin
         mode = 2'(m);
         for (int ei = 0; ei < 4; ei++) begin
            e = 16'h3A5C + 16'(ei) * 16'h1F17;
            e[10] = ei[0];
            for (int gi = 0; gi < 3; gi++) begin
               g = ((base << (gi * 12)) | (base >> (64 - gi * 12))) ^ (64'hF0F0_3C3C_A5A5_0FF0 * 64'(gi));
               if (m != 0 && e[10]) req = "R5";
               else if (m == 0) req = "R2";
               else if (m == 1) req = "R3";
               else req = "R4";
               run_cell(m, e, g, 0, 1'b0, req);
            end
         end
      end

      // R7 fine horizontal scroll, R8 line_start with hand-over
      mode = 2'd1;
      for (int f = 0; f < CW; f++) begin
         fine_h = 3'(f);
         e = 16'h5400 + 16'(f * 37);
         g = base ^ (64'h1111_2222_3333_4444 * 64'(f + 1));
         if (f % 2 == 1) begin
            run_cell(1, e, g, f, 1'b1, "R8");
         end else begin
            @(negedge clk); line_start = 1'b1;
            @(negedge clk); line_start = 1'b0;
            run_cell(1, e, g, f, 1'b0, "R7");
         end
         run_cell(1, e ^ 16'h0400, ~g, 0, 1'b0, "R7");
      end

      // R8 line_start mid-cell discards the rest, re-arms fine_h
      fine_h = 3'd0;
      mode = 2'd2;
      @(negedge clk);
      cell_entry = 16'h9123; cell_glyph = base; cell_valid = 1'b1;
      @(negedge clk);
      cell_valid = 1'b0;
      chk("R8", "pix before drop", 32'(pix_index), 32'(exp_pix(2, 16'h9123, base, 0)));
      @(negedge clk);
      @(negedge clk);
      line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      chk("R8", "pix_valid after drop", 32'(pix_valid), 32'd0);
      chk("R8", "cell_ready after drop", 32'(cell_ready), 32'd1);
      fine_h = 3'd3;
      run_cell(2, 16'h6C21, ~base, 3, 1'b0, "R7");

      // R6 back-to-back cells with no gap
      fine_h = 3'd0;
      e = 16'h7A0F; g = base; g2 = {base[31:0], base[63:32]};
      @(negedge clk);
      cell_entry = e; cell_glyph = g; cell_valid = 1'b1;
      @(negedge clk);
      cell_entry = 16'h24F1; cell_glyph = g2;
      for (int p = 0; p < CW; p++) begin
         chk("R6", "first cell pixel", 32'(pix_index), 32'(exp_pix(2, e, g, p)));
         chk("R6", "cell_ready hold", 32'(cell_ready), 32'(p == CW - 1));
         if (p < CW - 1) @(negedge clk);
      end
      @(negedge clk);
      cell_valid = 1'b0;
      for (int p = 0; p < CW; p++) begin
         chk("R6", "no gap valid", 32'(pix_valid), 32'd1);
         chk("R6", "second cell pixel", 32'(pix_index), 32'(exp_pix(2, 16'h24F1, g2, p)));
         if (p < CW - 1) @(negedge clk);
      end

      // R9 lookup address, R10 row tracking, R11 vertical mirror
      for (int c = 0; c < 5; c++) begin
         int tall, rl, fv, last, r, reff, gl;
         logic [15:0] ent;
         case (c)
            0: begin tall = 0; rl = 7;  fv = 3;  end
            1: begin tall = 1; rl = 15; fv = 5;  end
            2: begin tall = 1; rl = 10; fv = 12; end
            3: begin tall = 0; rl = 12; fv = 2;  end
            default: begin tall = 1; rl = 0; fv = 0; end
         endcase
         cell_tall = tall[0]; row_last = 4'(rl); fine_v = 4'(fv);
         last = (tall == 0 && rl > 7) ? 7 : rl;
         @(negedge clk); frame_start = 1'b1;
         @(negedge clk); frame_start = 1'b0;
         r = (fv > last) ? 0 : fv;
         for (int n = 0; n < 20; n++) begin
            for (int v = 0; v < 3; v++) begin
               if (v == 2) begin
                  mode = 2'd0; ent = 16'hA8C3; gl = 'hC3; reff = r; req = "R9";
               end else begin
                  mode = 2'd1; ent = {4'h6, v[0], 1'b0, 10'h2B5}; gl = 'h2B5;
                  reff = (v == 1) ? last - r : r;
                  req = (v == 1) ? "R11" : "R10";
               end
               lk_entry = ent;
               #1;
               chk(req, "lk_addr", 32'(lk_addr), 32'(tall != 0 ? gl * 16 + reff : gl * 8 + reff));
            end
            @(negedge clk); line_end = 1'b1;
            @(negedge clk); line_end = 1'b0;
            r = (r >= last) ? 0 : r + 1;
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule